// File: doc/BRIEF.md
# Serial link master control register file

This block is the software-visible control and status register file of a serial link master. It sits on a simple 32-bit slave bus: a one-cycle request (valid, write flag, byte address, write data) and a registered response (ready pulse with read data) one cycle later. Registers are 32 bits wide and word indexed, so the byte address shifted right by two selects the slot. Field bits are numbered big-endian, so field bit 0 is the most significant bit of the word.

Most slots are plain storage that returns what was written. Two port-enable words have special write semantics. Each has one address that replaces it, one that ORs bits into it and one that clears bits in it, so software can change single ports without a read-modify-write. The set and clear addresses are read back as separate status slots, not as the enable words. A write-only port reset slot discards what is written. A bridge reset slot lets software reset the whole register file: the reset lands one cycle after the write, and the acknowledge of that write is not held back. The version slot comes out of reset with a fixed non-zero value. The enable words and the two clock divider fields of the mode slot are driven out to the link engine.

Top module: `lnk_ctl_regs`

## Requirements
- R1: Every cycle with `req_valid` high is answered by `rsp_ready` high in the next cycle and only then. `rsp_rdata` carries the read data in that cycle and is zero when it answers a write.
- R2: After hardware reset every slot reads zero, except the version slot at byte offset 0x074, which reads 0xE0050101.
- R3: A write to any in-range offset not named in R4 to R9 stores the word unchanged, and a later read of that offset returns it. Address bits 1:0 are ignored.
- R4: A write to 0x010 replaces enable word 0 and a write to 0x014 replaces enable word 1. The new value is on `port_en_lo`/`port_en_hi` in the cycle after the write and reads back at 0x010/0x014.
- R5: A write to 0x018 (word 0) or 0x01C (word 1) ORs the write data into that enable word and leaves every other bit as it was.
- R6: A write to 0x020 (word 0) or 0x024 (word 1) clears every enable bit that is 1 in the write data and leaves every other bit as it was.
- R7: A read of 0x018, 0x01C, 0x020 or 0x024 returns the status slot held there, not the enable word. Writes never store into these slots, so they read zero.
- R8: A write to the port reset slot at 0x0D0 is discarded, and the slot reads zero.
- R9: A write to the bridge reset slot at 0x1D0 with bit 31 (general reset) or bit 30 (error reset) set is acknowledged as in R1 and returns every slot and output to its R2 value one cycle after it is accepted. Any write request in that following cycle is acknowledged but dropped. A write at 0x1D0 with neither bit set changes nothing, and the slot always reads zero.
- R10: `div_a` is mode-slot (0x000) bits 27:18, which are big-endian field bits 4-13. `div_b` is bits 17:8, which are field bits 14-23.
- R11: The implemented space is 0x400 bytes. A read at byte address 0x400 or above returns zero, and a write there changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Response pulse, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| port_en_lo | output | 32 | Port-enable word 0 |
| port_en_hi | output | 32 | Port-enable word 1 |
| div_a | output | 10 | First clock divider field of the mode slot |
| div_b | output | 10 | Second clock divider field of the mode slot |

## Verification
A wrong enable word appears on `port_en_lo`/`port_en_hi` in the cycle after the faulty set, clear or replace write. The bench compares those outputs right after every such write, so a merge that also changes bits it should leave alone is caught at once. A wrong decode of the alias or discard offsets stays hidden until the affected slot is read, so the bench reads each special offset after writing it, and every read is checked against a model as it comes back. A self-reset that lands a cycle early or late, or leaves a slot uncleared, shows up two cycles after the command write, when the outputs should already be at their reset values and the version slot should read its fixed value again.

// File: rtl/lnk_ctl_pkg.sv
package lnk_ctl_pkg;

  typedef logic [31:0] word_t;

  // Slot indices (byte offset >> 2) whose behaviour is special.
  localparam int unsigned IDX_MODE     = 0;
  localparam int unsigned IDX_PEN_BASE = 4;   // 0x010, 0x014 : replace
  localparam int unsigned IDX_SET_BASE = 6;   // 0x018, 0x01C : OR in
  localparam int unsigned IDX_CLR_BASE = 8;   // 0x020, 0x024 : AND-NOT
  localparam int unsigned IDX_VER      = 29;  // 0x074
  localparam int unsigned IDX_PRST     = 52;  // 0x0D0
  localparam int unsigned IDX_BRST     = 116; // 0x1D0
  localparam int unsigned N_PEN        = 2;

  localparam word_t VERSION_RST = 32'hE005_0101;

  typedef enum logic [2:0] {
    OP_STORE,
    OP_PEN_LOAD,
    OP_PEN_SET,
    OP_PEN_CLR,
    OP_DISCARD,
    OP_SELF_RESET
  } wr_op_e;

  // Big-endian bit n of a 32-bit word.
  function automatic word_t be_bit(input int unsigned n);
    return word_t'(1) << (31 - n);
  endfunction

  // Ten-bit field starting at big-endian bit 'first'.
  function automatic logic [9:0] be_field10(input word_t w, input int unsigned first);
    word_t sh;
    sh = w >> (31 - (first + 9));
    return sh[9:0];
  endfunction

  function automatic word_t reset_word(input int unsigned idx);
    return (idx == IDX_VER) ? VERSION_RST : '0;
  endfunction

  function automatic word_t merge_set(input word_t old_w, input word_t d);
    return old_w | d;
  endfunction

  function automatic word_t merge_clr(input word_t old_w, input word_t d);
    return old_w & ~d;
  endfunction

  // General reset (BE bit 0) or error reset (BE bit 1) requested.
  function automatic logic wants_reset(input word_t d);
    return |(d & (be_bit(0) | be_bit(1)));
  endfunction

endpackage

// File: rtl/lnk_ctl_decode.sv
module lnk_ctl_decode
  import lnk_ctl_pkg::*;
#(
  parameter int unsigned N_WORDS = 256
) (
  input  logic [$clog2(N_WORDS)-1:0]                  idx,
  output wr_op_e                                      op,
  output logic [((N_PEN > 1) ? $clog2(N_PEN) : 1)-1:0] sel,
  output logic                                        pen_rd_hit
);
  localparam int unsigned IDX_W = $clog2(N_WORDS);
  localparam int unsigned SEL_W = (N_PEN > 1) ? $clog2(N_PEN) : 1;

  always_comb begin
    op         = OP_STORE;
    sel        = '0;
    pen_rd_hit = 1'b0;
    if (idx == IDX_W'(IDX_PRST)) op = OP_DISCARD;
    if (idx == IDX_W'(IDX_BRST)) op = OP_SELF_RESET;
    for (int k = 0; k < N_PEN; k++) begin
      if (idx == IDX_W'(IDX_PEN_BASE + k)) begin
        op = OP_PEN_LOAD; sel = SEL_W'(k); pen_rd_hit = 1'b1;
      end
      if (idx == IDX_W'(IDX_SET_BASE + k)) begin
        op = OP_PEN_SET; sel = SEL_W'(k);
      end
      if (idx == IDX_W'(IDX_CLR_BASE + k)) begin
        op = OP_PEN_CLR; sel = SEL_W'(k);
      end
    end
  end
endmodule

// File: rtl/lnk_ctl_enable_word.sv
module lnk_ctl_enable_word
  import lnk_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_clr,
  input  logic  do_load,
  input  logic  do_set,
  input  logic  do_clr,
  input  word_t wdata,
  output word_t word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (soft_clr) word <= '0;
    else if (do_load)  word <= wdata;
    else if (do_set)   word <= merge_set(word, wdata);
    else if (do_clr)   word <= merge_clr(word, wdata);
  end
endmodule

// File: rtl/lnk_ctl_store.sv
module lnk_ctl_store
  import lnk_ctl_pkg::*;
#(
  parameter int unsigned N_WORDS = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       soft_clr,
  input  logic                       we,
  input  logic [$clog2(N_WORDS)-1:0] widx,
  input  word_t                      wdata,
  input  logic [$clog2(N_WORDS)-1:0] ridx,
  output word_t                      rdata,
  output word_t                      mode_word
);
  localparam int unsigned IDX_W = $clog2(N_WORDS);

  word_t mem [N_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WORDS; i++) mem[i] <= reset_word(i);
    end else if (soft_clr) begin
      for (int i = 0; i < N_WORDS; i++) mem[i] <= reset_word(i);
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata     = mem[ridx];
  assign mode_word = mem[IDX_W'(IDX_MODE)];
endmodule

// File: rtl/lnk_ctl_regs.sv
module lnk_ctl_regs
  import lnk_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SPACE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [31:0]       port_en_lo,
  output logic [31:0]       port_en_hi,
  output logic [9:0]        div_a,
  output logic [9:0]        div_b
);
  localparam int unsigned N_WORDS = SPACE_BYTES / 4;
  localparam int unsigned IDX_W   = $clog2(N_WORDS);
  localparam int unsigned SEL_W   = (N_PEN > 1) ? $clog2(N_PEN) : 1;

  logic [IDX_W-1:0] idx;
  logic             in_range;
  wr_op_e           dec_op;
  logic [SEL_W-1:0] dec_sel;
  logic             pen_rd_hit;
  logic             acc_wr;
  logic             soft_rst_pend;
  logic             soft_rst_req;
  logic [N_PEN-1:0] ev_load, ev_set, ev_clr;
  word_t            pen_q [N_PEN];
  word_t            store_rdata, mode_word, rd_word;

  assign idx      = req_addr[IDX_W+1:2];
  assign in_range = (req_addr < ADDR_W'(SPACE_BYTES));
  // Writes in the cycle the self-reset lands are dropped.
  assign acc_wr   = req_valid & req_write & in_range & ~soft_rst_pend;
  assign soft_rst_req = acc_wr & (dec_op == OP_SELF_RESET) & wants_reset(req_wdata);

  lnk_ctl_decode #(.N_WORDS(N_WORDS)) u_dec (
    .idx(idx), .op(dec_op), .sel(dec_sel), .pen_rd_hit(pen_rd_hit)
  );

  for (genvar k = 0; k < N_PEN; k++) begin : g_pen
    assign ev_load[k] = acc_wr & (dec_op == OP_PEN_LOAD) & (dec_sel == SEL_W'(k));
    assign ev_set[k]  = acc_wr & (dec_op == OP_PEN_SET)  & (dec_sel == SEL_W'(k));
    assign ev_clr[k]  = acc_wr & (dec_op == OP_PEN_CLR)  & (dec_sel == SEL_W'(k));
    lnk_ctl_enable_word u_word (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst_pend),
      .do_load(ev_load[k]), .do_set(ev_set[k]), .do_clr(ev_clr[k]),
      .wdata(req_wdata), .word(pen_q[k])
    );
  end

  lnk_ctl_store #(.N_WORDS(N_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst_pend),
    .we(acc_wr & (dec_op == OP_STORE)), .widx(idx), .wdata(req_wdata),
    .ridx(idx), .rdata(store_rdata), .mode_word(mode_word)
  );

  assign rd_word = pen_rd_hit ? pen_q[dec_sel] : store_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready     <= 1'b0;
      rsp_rdata     <= '0;
      soft_rst_pend <= 1'b0;
    end else begin
      rsp_ready     <= req_valid;
      rsp_rdata     <= (req_valid & ~req_write & in_range) ? rd_word : '0;
      soft_rst_pend <= soft_rst_req;
    end
  end

  assign port_en_lo = pen_q[0];
  assign port_en_hi = pen_q[1];
  assign div_a      = be_field10(mode_word, 4);
  assign div_b      = be_field10(mode_word, 14);
endmodule

// File: rtl/lnk_ctl_regs_chk.sv
module lnk_ctl_regs_chk #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SPACE_BYTES = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [31:0]       port_en_lo,
  input logic [31:0]       port_en_hi,
  input logic [9:0]        div_a,
  input logic [9:0]        div_b,
  input logic [1:0]        ev_set,
  input logic [1:0]        ev_clr,
  input logic              soft_rst_pend
);
  a_r1_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);
  a_r1_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);
  a_r1_write_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 32'h0));
  a_r5_set_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[0] |=> ((port_en_lo & $past(req_wdata)) == $past(req_wdata)));
  a_r5_set_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[1] |=> ((port_en_hi & $past(req_wdata)) == $past(req_wdata)));
  a_r6_clr_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr[0] |=> ((port_en_lo & $past(req_wdata)) == 32'h0));
  a_r6_clr_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr[1] |=> ((port_en_hi & $past(req_wdata)) == 32'h0));
  a_r9_self_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pend |=> (port_en_lo == 32'h0 && port_en_hi == 32'h0 &&
                       div_a == 10'h0 && div_b == 10'h0));
  a_r11_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr >= ADDR_W'(SPACE_BYTES))) |=> (rsp_rdata == 32'h0));
endmodule

bind lnk_ctl_regs lnk_ctl_regs_chk #(.ADDR_W(ADDR_W), .SPACE_BYTES(SPACE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .port_en_lo(port_en_lo), .port_en_hi(port_en_hi),
  .div_a(div_a), .div_b(div_b), .ev_set(ev_set), .ev_clr(ev_clr),
  .soft_rst_pend(soft_rst_pend)
);

// File: tb/lnk_ctl_regs_tb.sv
module lnk_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic [31:0] port_en_lo, port_en_hi;
  logic [9:0]  div_a, div_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] mdl [256];
  logic [31:0] q_exp [$];
  string       q_tag [$];

  always #4 clk = ~clk;

  lnk_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .port_en_lo(port_en_lo), .port_en_hi(port_en_hi),
    .div_a(div_a), .div_b(div_b)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) mdl[i] = 32'h0;
    mdl[29] = 32'hE005_0101;
  endtask

  // Model updated from the requirement text.
  task automatic model_write(input logic [15:0] a, input logic [31:0] d);
    int i;
    if (a >= 16'h0400) return;                        // R11
    i = int'(a >> 2);
    case (i)
      4, 5:    mdl[i]     = d;                         // R4
      6, 7:    mdl[i - 2] = mdl[i - 2] | d;            // R5
      8, 9:    mdl[i - 4] = mdl[i - 4] & ~d;           // R6
      52:      ;                                       // R8
      116:     if (d[31] || d[30]) model_reset();      // R9
      default: mdl[i] = d;                             // R3
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [15:0] a);
    if (a >= 16'h0400) return 32'h0;
    return mdl[int'(a >> 2)];
  endfunction

  // Driver: one request, expected response pushed to the scoreboard.
  task automatic bus(input bit wr, input logic [15:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    q_exp.push_back(wr ? 32'h0 : model_read(a));
    q_tag.push_back(tag);
    if (wr) model_write(a, d);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // Monitor: pops one expected item per response (R1).
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (rsp_ready) begin
        if (q_exp.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R1 unexpected ack actual=1 expected=0");
        end else begin
          check(q_tag.pop_front(), rsp_rdata, q_exp.pop_front());
        end
      end else if (q_exp.size() != 0) begin
        n_tests++; n_fail++;
        $display("FAIL R1 missing ack for %s actual=0 expected=1", q_tag.pop_front());
        void'(q_exp.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 port_en_lo", port_en_lo, 32'h0);
    check("R2 port_en_hi", port_en_hi, 32'h0);
    bus(0, 16'h0074, 0, "R2 version");
    bus(0, 16'h0000, 0, "R2 mode");
    bus(0, 16'h0010, 0, "R2 enable lo");
    // R3 plain storage, low bits ignored
    bus(1, 16'h0004, 32'hA5A5_0F0F, "R3 write");
    bus(1, 16'h02E3, 32'h1234_5678, "R3 write unaligned");
    bus(0, 16'h0004, 0, "R3 read 0x004");
    bus(0, 16'h02E0, 0, "R3 read 0x2E0");
    bus(1, 16'h03FC, 32'hDEAD_BEEF, "R3 top slot");
    bus(0, 16'h03FC, 0, "R3 read top slot");
    // R4 replace
    bus(1, 16'h0010, 32'hF0F0_1234, "R4 load lo");
    check("R4 port_en_lo", port_en_lo, 32'hF0F0_1234);
    bus(1, 16'h0014, 32'h0000_00FF, "R4 load hi");
    check("R4 port_en_hi", port_en_hi, 32'h0000_00FF);
    bus(0, 16'h0014, 0, "R4 read hi");
    // R5 set
    bus(1, 16'h0018, 32'h0F00_0001, "R5 set lo");
    check("R5 port_en_lo", port_en_lo, 32'hFFF0_1235);
    bus(1, 16'h001C, 32'h8000_0000, "R5 set hi");
    check("R5 port_en_hi", port_en_hi, 32'h8000_00FF);
    // R6 clear
    bus(1, 16'h0020, 32'hF000_0005, "R6 clr lo");
    check("R6 port_en_lo", port_en_lo, 32'h0FF0_1230);
    bus(1, 16'h0024, 32'h0000_000F, "R6 clr hi");
    check("R6 port_en_hi", port_en_hi, 32'h8000_00F0);
    bus(0, 16'h0010, 0, "R6 read lo");
    // R7 alias reads show status slots
    bus(0, 16'h0018, 0, "R7 read 0x018");
    bus(0, 16'h001C, 0, "R7 read 0x01C");
    bus(0, 16'h0020, 0, "R7 read 0x020");
    bus(0, 16'h0024, 0, "R7 read 0x024");
    // R8 port reset discarded
    bus(1, 16'h00D0, 32'hFFFF_FFFF, "R8 write");
    bus(0, 16'h00D0, 0, "R8 read");
    check("R8 port_en_lo kept", port_en_lo, 32'h0FF0_1230);
    // R10 mode divider fields
    bus(1, 16'h0000, 32'h0ABC_DE00 | (32'd517 << 18) | (32'd3 << 8), "R10 write mode");
    check("R10 div_a", {22'h0, div_a}, {22'h0, 10'(((32'h0ABC_DE00 >> 18) | 32'd517) & 32'h3FF)});
    check("R10 div_b", {22'h0, div_b}, {22'h0, 10'(((32'h0ABC_DE00 >> 8) | 32'd3) & 32'h3FF)});
    // R11 out of range
    bus(1, 16'h0404, 32'h5555_5555, "R11 oob write");
    bus(0, 16'h0004, 0, "R11 no alias write");
    bus(0, 16'h0404, 0, "R11 oob read");
    bus(0, 16'hFFFC, 0, "R11 far read");
    // R9 bridge reset without reset bits
    bus(1, 16'h01D0, 32'h3FFF_FFFF, "R9 no-op write");
    @(negedge clk);
    check("R9 no-op keeps lo", port_en_lo, 32'h0FF0_1230);
    bus(0, 16'h01D0, 0, "R9 read zero");
    // R9 general reset (bit 31)
    bus(1, 16'h01D0, 32'h8000_0000, "R9 general reset ack");
    @(negedge clk);
    check("R9 lo cleared", port_en_lo, 32'h0);
    check("R9 hi cleared", port_en_hi, 32'h0);
    check("R9 div_a cleared", {22'h0, div_a}, 32'h0);
    bus(0, 16'h0074, 0, "R9 version back");
    bus(0, 16'h0004, 0, "R9 storage cleared");
    // R9 error reset (bit 30)
    bus(1, 16'h0014, 32'h0000_0101, "R9 prep hi");
    bus(1, 16'h0074, 32'h1111_2222, "R9 prep ver");
    bus(0, 16'h0074, 0, "R3 version writable");
    bus(1, 16'h01D0, 32'h4000_0000, "R9 error reset ack");
    @(negedge clk);
    check("R9 err hi cleared", port_en_hi, 32'h0);
    bus(0, 16'h0074, 0, "R9 err version back");
    repeat (3) @(negedge clk);
    check("R1 queue drained", 32'(q_exp.size()), 32'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule